// File: doc/BRIEF.md
# Register Result Status Rename Table

This block keeps, for every architectural floating-point register, the current register value together with a producer tag. The tag names the reservation station that will deliver the register's next value, or is zero when no instruction in flight writes the register. During issue, the block looks up the instruction's source registers. For each source it returns either a usable value with tag zero, or the tag of the station the waiting instruction must watch on the result bus. In the same cycle it records the issuing station's tag against the destination register.

Renaming happens by overwriting the tag. A younger writer of a register replaces the older writer's tag, so only the latest producer can update the register, and write-after-write ordering never causes a stall. Results come back over a shared broadcast bus that carries a tag and data. Every register whose stored tag equals the broadcast tag takes the data and drops back to tag zero. Waiting stations keep copies of the old values they were given, so write-after-read hazards do not arise. The stations and execution units themselves sit outside this block.

Top module: `rrs_rename_table`

## Requirements
- R1: After reset every register holds value zero and tag zero, so every lookup returns value 0 and tag 0.
- R2: A lookup of a register whose tag is zero returns its stored value and tag 0. A lookup of a register with a nonzero tag returns that tag. Tag 0 means "no producer", and stations are numbered 1 to NUM_STATIONS.
- R3: An issue with valid high records the issue tag against the destination register, and a lookup sees it from the next cycle.
- R4: A second issue to the same destination overwrites the earlier tag. A later broadcast of the older tag then leaves that register unchanged.
- R5: A valid broadcast writes its data into every register whose stored nonzero tag equals the broadcast tag, and clears those tags to zero, visible the next cycle.
- R6: A broadcast with valid low, with tag zero, or with a tag that matches no register changes no register value or tag.
- R7: When an issue and a matching broadcast hit the same register in one cycle, the register takes the issue tag and keeps its old value.
- R8: A lookup of a register whose stored nonzero tag equals the tag being broadcast in that cycle returns the broadcast data with tag 0.
- R9: Lookups in the cycle of an issue see the table as it stood before that issue, even when a source equals the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | Station tag of the issuing instruction, nonzero |
| iss_src | input | NUM_SRC x IDX_W | Source register indices to look up |
| bus_valid | input | 1 | Result bus carries a result this cycle |
| bus_tag | input | TAG_W | Tag of the producing station |
| bus_data | input | DATA_W | Result value |
| src_value | output | NUM_SRC x DATA_W | Value per source (meaningful when its tag is 0) |
| src_tag | output | NUM_SRC x TAG_W | Producer tag per source, 0 when the value is ready |

## Verification
The assertions take it for granted that an issuing instruction always carries a nonzero station tag and a destination index below the register count. Two assertions state these assumptions at the inputs. The random stimulus draws issue tags from 1 to NUM_STATIONS and register indices from 0 to NUM_REGS-1, so it stays inside both. Broadcast tags may be zero, stale or unmatched on purpose, because the table must tolerate them. About half the broadcasts reuse a tag that is currently pending in the table, so that matches, multi-register writes and same-cycle collisions with issue occur often.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   // Width of a station tag: one code reserved for "no producer".
   function automatic int tag_width(input int stations);
      return $clog2(stations + 1);
   endfunction

   // Width of a register index, never below one bit.
   function automatic int index_width(input int regs);
      return (regs > 1) ? $clog2(regs) : 1;
   endfunction

endpackage

// File: rtl/rrs_claim_decode.sv
module rrs_claim_decode #(
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 3
) (
   input  logic                iss_valid,
   input  logic [IDX_W-1:0]    iss_dst,
   output logic [NUM_REGS-1:0] claim
);

   // One select line per register entry.
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_claim
      assign claim[r] = iss_valid && (int'(iss_dst) == r);
   end

endmodule

// File: rtl/rrs_entry.sv
module rrs_entry #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              claim,
   input  logic [TAG_W-1:0]  claim_tag,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   output logic [TAG_W-1:0]  cur_tag,
   output logic [DATA_W-1:0] cur_value
);

   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] value_q;
   logic              bus_hit;

   assign bus_hit = bus_valid && (tag_q != '0) && (tag_q == bus_tag);

   // A new claim outranks a completing producer; the value stays put then.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q   <= '0;
         value_q <= '0;
      end else if (claim) begin
         tag_q   <= claim_tag;
      end else if (bus_hit) begin
         tag_q   <= '0;
         value_q <= bus_data;
      end
   end

   assign cur_tag   = tag_q;
   assign cur_value = value_q;

   AST_CLAIM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      claim |=> (cur_tag == $past(claim_tag)) && (cur_value == $past(cur_value))); // R7

   AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!claim && bus_valid && cur_tag != '0 && bus_tag == cur_tag)
      |=> (cur_tag == '0) && (cur_value == $past(bus_data))); // R5

   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!claim && !(bus_valid && cur_tag != '0 && bus_tag == cur_tag))
      |=> $stable(cur_tag) && $stable(cur_value)); // R6

endmodule

// File: rtl/rrs_lookup.sv
module rrs_lookup #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 3,
   parameter int IDX_W    = 3
) (
   input  logic [IDX_W-1:0]                 sel,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]   all_tag,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  all_value,
   input  logic                             bus_valid,
   input  logic [TAG_W-1:0]                 bus_tag,
   input  logic [DATA_W-1:0]                bus_data,
   output logic [DATA_W-1:0]                out_value,
   output logic [TAG_W-1:0]                 out_tag
);

   logic [TAG_W-1:0]  raw_tag;
   logic [DATA_W-1:0] raw_value;
   logic              bypass;

   // Index beyond the table reads as an idle register.
   always_comb begin
      raw_tag   = '0;
      raw_value = '0;
      if (int'(sel) < NUM_REGS) begin
         raw_tag   = all_tag[sel];
         raw_value = all_value[sel];
      end
   end

   assign bypass = bus_valid && (raw_tag != '0) && (raw_tag == bus_tag);

   always_comb begin
      if (bypass) begin
         out_value = bus_data;
         out_tag   = '0;
      end else begin
         out_value = raw_value;
         out_tag   = raw_tag;
      end
   end

endmodule

// File: rtl/rrs_rename_table.sv
module rrs_rename_table
   import rrs_pkg::*;
#(
   parameter int NUM_REGS     = 8,
   parameter int NUM_STATIONS = 5,
   parameter int DATA_W       = 32,
   parameter int NUM_SRC      = 2,
   localparam int TAG_W       = tag_width(NUM_STATIONS),
   localparam int IDX_W       = index_width(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             iss_valid,
   input  logic [IDX_W-1:0]                 iss_dst,
   input  logic [TAG_W-1:0]                 iss_tag,
   input  logic [NUM_SRC-1:0][IDX_W-1:0]    iss_src,
   input  logic                             bus_valid,
   input  logic [TAG_W-1:0]                 bus_tag,
   input  logic [DATA_W-1:0]                bus_data,
   output logic [NUM_SRC-1:0][DATA_W-1:0]   src_value,
   output logic [NUM_SRC-1:0][TAG_W-1:0]    src_tag
);

   // Elaboration-time parameter checks.
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("rrs_rename_table: NUM_REGS must be at least 2");
   end
   if (NUM_STATIONS < 1) begin : g_bad_stations
      $error("rrs_rename_table: NUM_STATIONS must be at least 1");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("rrs_rename_table: NUM_SRC must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("rrs_rename_table: DATA_W must be at least 1");
   end

   logic [NUM_REGS-1:0]              claim;
   logic [NUM_REGS-1:0][TAG_W-1:0]   entry_tag;
   logic [NUM_REGS-1:0][DATA_W-1:0]  entry_value;

   rrs_claim_decode #(
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) i_decode (
      .iss_valid (iss_valid),
      .iss_dst   (iss_dst),
      .claim     (claim)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
      rrs_entry #(
         .DATA_W (DATA_W),
         .TAG_W  (TAG_W)
      ) i_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .claim     (claim[r]),
         .claim_tag (iss_tag),
         .bus_valid (bus_valid),
         .bus_tag   (bus_tag),
         .bus_data  (bus_data),
         .cur_tag   (entry_tag[r]),
         .cur_value (entry_value[r])
      );
   end

   for (genvar p = 0; p < NUM_SRC; p++) begin : g_port
      rrs_lookup #(
         .NUM_REGS (NUM_REGS),
         .DATA_W   (DATA_W),
         .TAG_W    (TAG_W),
         .IDX_W    (IDX_W)
      ) i_lookup (
         .sel       (iss_src[p]),
         .all_tag   (entry_tag),
         .all_value (entry_value),
         .bus_valid (bus_valid),
         .bus_tag   (bus_tag),
         .bus_data  (bus_data),
         .out_value (src_value[p]),
         .out_tag   (src_tag[p])
      );

      // A bypassed value must be the one the register holds next cycle.
      AST_BYPASS_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
         (src_tag[p] == '0 && bus_valid && bus_tag != '0
          && entry_tag[iss_src[p]] == bus_tag
          && !(iss_valid && iss_dst == iss_src[p]))
         |=> entry_value[$past(iss_src[p])] == $past(src_value[p])); // R8
   end

   // Input assumptions relied on by the entries.
   AST_ISSUE_TAG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (iss_tag != '0) && (int'(iss_tag) <= NUM_STATIONS)); // R2

   AST_ISSUE_DST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> int'(iss_dst) < NUM_REGS); // R3

   AST_SINGLE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim) && (iss_valid || claim == '0)); // R4

endmodule

// File: tb/test_rrs_rename_table.sv
module test_rrs_rename_table;

   localparam int NR = 8;
   localparam int NS = 5;
   localparam int DW = 32;
   localparam int NP = 2;
   localparam int TW = 3;
   localparam int IW = 3;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic                  iss_valid;
   logic [IW-1:0]         iss_dst;
   logic [TW-1:0]         iss_tag;
   logic [NP-1:0][IW-1:0] iss_src;
   logic                  bus_valid;
   logic [TW-1:0]         bus_tag;
   logic [DW-1:0]         bus_data;
   logic [NP-1:0][DW-1:0] src_value;
   logic [NP-1:0][TW-1:0] src_tag;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 0;

   logic [DW-1:0] m_val [NR];
   logic [TW-1:0] m_tag [NR];

   always #10 clk = ~clk;

   rrs_rename_table #(
      .NUM_REGS     (NR),
      .NUM_STATIONS (NS),
      .DATA_W       (DW),
      .NUM_SRC      (NP)
   ) i_rrs_rename_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .iss_dst   (iss_dst),
      .iss_tag   (iss_tag),
      .iss_src   (iss_src),
      .bus_valid (bus_valid),
      .bus_tag   (bus_tag),
      .bus_data  (bus_data),
      .src_value (src_value),
      .src_tag   (src_tag)
   );

   function automatic logic [DW-1:0] exp_value(input int r);
      if (m_tag[r] != 0 && bus_valid && bus_tag == m_tag[r]) return bus_data;
      return m_val[r];
   endfunction

   function automatic logic [TW-1:0] exp_tag(input int r);
      if (m_tag[r] != 0 && bus_valid && bus_tag == m_tag[r]) return '0;
      return m_tag[r];
   endfunction

   task automatic compare_ports(input string req);
      for (int p = 0; p < NP; p++) begin
         int r = int'(iss_src[p]);
         compared++;
         if (src_value[p] !== exp_value(r) || src_tag[p] !== exp_tag(r)) begin
            mismatched++;
            $display("FAIL %s port %0d reg %0d: actual value %h tag %0d expected value %h tag %0d",
                     req, p, r, src_value[p], src_tag[p], exp_value(r), exp_tag(r));
         end
      end
   endtask

   task automatic model_update();
      for (int r = 0; r < NR; r++) begin
         if (iss_valid && int'(iss_dst) == r) begin
            m_tag[r] = iss_tag;
         end else if (bus_valid && m_tag[r] != 0 && m_tag[r] == bus_tag) begin
            m_val[r] = bus_data;
            m_tag[r] = '0;
         end
      end
   endtask

   task automatic step(input bit iv, input int dst, input int tg, input int s0, input int s1,
                       input bit bv, input int bt, input logic [DW-1:0] bd, input string req);
      @(negedge clk);
      iss_valid  = iv;
      iss_dst    = IW'(dst);
      iss_tag    = TW'(tg);
      iss_src[0] = IW'(s0);
      iss_src[1] = IW'(s1);
      bus_valid  = bv;
      bus_tag    = TW'(bt);
      bus_data   = bd;
      #2;
      compare_ports(req);
      @(posedge clk);
      model_update();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL R1 watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int r = 0; r < NR; r++) begin
         m_val[r] = '0;
         m_tag[r] = '0;
      end
      rst_n = 1'b0; iss_valid = 0; iss_dst = '0; iss_tag = '0; iss_src = '0;
      bus_valid = 0; bus_tag = '0; bus_data = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every register idle and zero after reset
      for (int r = 0; r < NR; r += 2) begin
         step(0, 0, 1, r, r + 1, 0, 0, '0, "R1 reset");
         for (int p = 0; p < NP; p++) begin
            compared++;
            if (src_value[p] !== '0 || src_tag[p] !== '0) begin
               mismatched++;
               $display("FAIL R1 reset port %0d: actual %h/%0d expected 0/0", p, src_value[p], src_tag[p]);
            end
         end
      end

      // R3: issue records tag
      step(1, 3, 2, 0, 0, 0, 0, '0, "R3 issue");
      step(1, 5, 2, 3, 5, 0, 0, '0, "R3 R2 tag visible");
      // R5: one broadcast writes two registers
      step(0, 0, 1, 3, 5, 1, 2, 32'hA5A5_0001, "R8 bypass on both");
      step(0, 0, 1, 3, 5, 0, 0, '0, "R5 multi write");

      // R4: write-after-write overwrite
      step(1, 1, 1, 1, 0, 0, 0, '0, "R4 first writer");
      step(1, 1, 4, 1, 0, 0, 0, '0, "R4 second writer");
      step(0, 0, 1, 1, 0, 1, 1, 32'h0000_0111, "R4 stale result");
      step(0, 0, 1, 1, 0, 1, 4, 32'h0000_0444, "R4 latest result");
      step(0, 0, 1, 1, 0, 0, 0, '0, "R4 value");

      // R7: issue and broadcast collide on one register
      step(1, 2, 3, 2, 2, 0, 0, '0, "R7 setup");
      step(1, 2, 5, 4, 4, 1, 3, 32'h0000_0333, "R7 collide");
      step(0, 0, 1, 2, 2, 0, 0, '0, "R7 issue wins");

      // R8: same-cycle bypass
      step(1, 6, 1, 6, 6, 0, 0, '0, "R8 setup");
      step(0, 0, 1, 6, 2, 1, 1, 32'h0000_0066, "R8 bypass");
      // R9: source equals destination in issue cycle
      step(1, 6, 2, 6, 6, 0, 0, '0, "R9 pre-issue view");
      step(0, 0, 1, 6, 6, 0, 0, '0, "R9 after issue");

      // R6: broadcasts that must not write
      step(0, 0, 1, 6, 2, 1, 0, 32'hDEAD_0000, "R6 tag zero");
      step(0, 0, 1, 6, 2, 0, 2, 32'hDEAD_0001, "R6 valid low");
      step(0, 0, 1, 6, 2, 0, 0, '0, "R6 unchanged");
      step(0, 0, 1, 0, 7, 1, 3, 32'hDEAD_0002, "R6 unmatched");
      step(0, 0, 1, 0, 7, 0, 0, '0, "R6 idle regs");

      // Constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         bit iv = ($urandom % 3) != 0;
         bit bv = ($urandom % 2) != 0;
         int bt;
         if (($urandom % 2) != 0) bt = int'(m_tag[$urandom % NR]);
         else                     bt = $urandom % (NS + 1);
         step(iv, $urandom % NR, 1 + ($urandom % NS), $urandom % NR, $urandom % NR,
              bv, bt, $urandom, "R2 R5 R8 random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule